// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits on the outbound request path of a PCIe root port. It turns a 64-bit CPU-side address into a PCIe-side address by looking it up in a bank of programmable windows. Each window has a 64-bit compare value, a 64-bit mask, a 64-bit replacement value and an action word that selects a memory or an I/O transaction. For each request the block reports the translated address, the transaction kind, whether a window hit or missed, and which window hit.

Software loads the windows through a simple write port with a combinational read-back. A window is switched on last, by setting the lowest bit of its low compare word. A global enable input and a per-request bypass flag let traffic skip translation. Configuration PIO traffic uses the bypass flag.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream through one output register. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`rsp_ready` high). While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and no new request is taken.

Top module: `obw_translator`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, every window register reads 0, and so every window is switched off.
- R2: `cfg_addr[7:5]` selects the window and `cfg_addr[4:0]` the byte offset inside it. The offsets are: 0x00 compare low, 0x04 compare high, 0x08 replacement low, 0x0C replacement high, 0x10 mask low, 0x14 mask high, 0x18 action. Written words read back unchanged on `cfg_rdata`. Offset 0x1C reads 0 and writes to it are ignored.
- R3: A window whose compare-low bit 0 is clear never hits, whatever the address.
- R4: A switched-on window hits when `(addr & mask) == (compare & mask)`. Bit 0 of the compare value is left out of that comparison, and the high 32 bits take part in it.
- R5: On a hit, `rsp_addr = (replacement & mask) | (addr & ~mask)`.
- R6: `rsp_io` is 1 when the low nibble of the hitting window's action word is 0x4 (I/O). It is 0 when that nibble is 0x0 (memory), and 0 when there is no hit.
- R7: When several windows hit, the lowest-numbered one is used, and `rsp_win` gives its index.
- R8: With translation active and no window hitting, `rsp_addr` equals the request address, `rsp_miss` is 1 and `rsp_hit` is 0. `rsp_hit` and `rsp_miss` are never both 1.
- R9: When `glb_en` is 0, or `req_bypass` is 1, the address passes through unchanged with `rsp_hit`, `rsp_miss`, `rsp_io` and `rsp_win` all 0.
- R10: A request accepted at one clock edge has its result valid right after that edge. The lookup uses the window state from before any register write made at the same edge.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and all response outputs stay stable. Raising `rsp_ready` lets a waiting request in at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global translation enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address (window, offset) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 64 | CPU-side address |
| req_bypass | input | 1 | Skip translation for this request |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_io | output | 1 | 1 = I/O transaction, 0 = memory |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | Translation active but no window matched |
| rsp_win | output | 3 | Index of the window that matched |

## Verification
Two things can fall in the same cycle here: a register write that switches a window on, and a lookup whose address falls in that window. The bench drives both at one edge and expects a miss, because the old state applies. The next lookup must then hit. The second overlap is back-pressure against a new request. A result is stalled with `rsp_ready` low while another request waits. The bench checks that the held result does not change, then releases the stall and expects the waiting request's result right after the releasing edge.

// File: rtl/obw_pkg.sv
package obw_pkg;
  localparam int ADDR_W = 64;
  localparam int DATA_W = 32;
  localparam int OFS_W  = 5;

  // Word select inside a window block (cfg_addr[4:2])
  localparam logic [2:0] F_CMP_LO = 3'd0;
  localparam logic [2:0] F_CMP_HI = 3'd1;
  localparam logic [2:0] F_REP_LO = 3'd2;
  localparam logic [2:0] F_REP_HI = 3'd3;
  localparam logic [2:0] F_MSK_LO = 3'd4;
  localparam logic [2:0] F_MSK_HI = 3'd5;
  localparam logic [2:0] F_ACT    = 3'd6;

  localparam logic [3:0] KIND_IO  = 4'h4;

  typedef struct packed {
    logic [ADDR_W-1:0] cmp;
    logic [ADDR_W-1:0] msk;
    logic [ADDR_W-1:0] rep;
    logic [DATA_W-1:0] act;
  } obw_win_t;
endpackage

// File: rtl/obw_regbank.sv
module obw_regbank
  import obw_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_BITS = $clog2(NUM_WIN),
  localparam int CFG_AW = WIN_BITS + OFS_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [CFG_AW-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output obw_win_t [NUM_WIN-1:0]      wins
);
  logic [WIN_BITS-1:0] win_sel;
  logic [2:0]          fld;
  logic                sel_ok;
  obw_win_t [NUM_WIN-1:0] bank_q;

  assign win_sel = addr[CFG_AW-1:OFS_W];
  assign fld     = addr[OFS_W-1:2];
  assign sel_ok  = int'(win_sel) < NUM_WIN;
  assign wins    = bank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (we && sel_ok) begin
      case (fld)
        F_CMP_LO: bank_q[win_sel].cmp[DATA_W-1:0]      <= wdata;
        F_CMP_HI: bank_q[win_sel].cmp[ADDR_W-1:DATA_W] <= wdata;
        F_REP_LO: bank_q[win_sel].rep[DATA_W-1:0]      <= wdata;
        F_REP_HI: bank_q[win_sel].rep[ADDR_W-1:DATA_W] <= wdata;
        F_MSK_LO: bank_q[win_sel].msk[DATA_W-1:0]      <= wdata;
        F_MSK_HI: bank_q[win_sel].msk[ADDR_W-1:DATA_W] <= wdata;
        F_ACT:    bank_q[win_sel].act                  <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ok) begin
      case (fld)
        F_CMP_LO: rdata = bank_q[win_sel].cmp[DATA_W-1:0];
        F_CMP_HI: rdata = bank_q[win_sel].cmp[ADDR_W-1:DATA_W];
        F_REP_LO: rdata = bank_q[win_sel].rep[DATA_W-1:0];
        F_REP_HI: rdata = bank_q[win_sel].rep[ADDR_W-1:DATA_W];
        F_MSK_LO: rdata = bank_q[win_sel].msk[DATA_W-1:0];
        F_MSK_HI: rdata = bank_q[win_sel].msk[ADDR_W-1:DATA_W];
        F_ACT:    rdata = bank_q[win_sel].act;
        default:  rdata = '0;
      endcase
    end
  end

  // R2: a write to the unused slot leaves the window's action word alone
  a_r2_spare_slot_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && fld == 3'd7 && sel_ok) |=> $stable(bank_q[$past(win_sel)].act));
endmodule

// File: rtl/obw_winmatch.sv
module obw_winmatch
  import obw_pkg::*;
(
  input  obw_win_t            win,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [ADDR_W-1:0]   xaddr,
  output logic                is_io
);
  logic              armed;
  logic [ADDR_W-1:0] cmp_msk;

  assign armed   = win.cmp[0];
  assign cmp_msk = win.msk & ~ADDR_W'(1);
  assign hit     = armed && (((addr ^ win.cmp) & cmp_msk) == '0);
  assign xaddr   = (win.rep & win.msk) | (addr & ~win.msk);
  assign is_io   = (win.act[3:0] == KIND_IO);
endmodule

// File: rtl/obw_prio.sv
module obw_prio #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/obw_translator.sv
module obw_translator
  import obw_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int WIN_BITS = $clog2(NUM_WIN),
  localparam int CFG_AW = WIN_BITS + OFS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                glb_en,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_bypass,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [ADDR_W-1:0]   rsp_addr,
  output logic                rsp_io,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic [WIN_BITS-1:0] rsp_win
);
  obw_win_t [NUM_WIN-1:0] wins;
  logic [NUM_WIN-1:0]     hit_vec;
  logic [NUM_WIN-1:0]     io_vec;
  logic [ADDR_W-1:0]      xaddr [NUM_WIN];
  logic [NUM_WIN-1:0]     grant;
  logic                   any_hit;
  logic [WIN_BITS-1:0]    win_idx;
  logic [ADDR_W-1:0]      sel_addr;
  logic                   sel_io;
  logic                   xlate_on;
  logic                   accept;

  obw_regbank #(.NUM_WIN(NUM_WIN)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .wins  (wins)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    obw_winmatch u_match (
      .win   (wins[g]),
      .addr  (req_addr),
      .hit   (hit_vec[g]),
      .xaddr (xaddr[g]),
      .is_io (io_vec[g])
    );
  end

  obw_prio #(.N(NUM_WIN)) u_prio (
    .req   (hit_vec),
    .grant (grant),
    .any   (any_hit),
    .idx   (win_idx)
  );

  // AND-OR select of the granted window's result
  always_comb begin
    sel_addr = '0;
    sel_io   = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      sel_addr = sel_addr | (xaddr[i] & {ADDR_W{grant[i]}});
      sel_io   = sel_io | (io_vec[i] & grant[i]);
    end
  end

  assign xlate_on  = glb_en && !req_bypass;
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
      rsp_io    <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= xlate_on && any_hit;
      rsp_miss  <= xlate_on && !any_hit;
      rsp_addr  <= (xlate_on && any_hit) ? sel_addr : req_addr;
      rsp_io    <= xlate_on && any_hit && sel_io;
      rsp_win   <= (xlate_on && any_hit) ? win_idx : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7: at most one window granted, only among hitting ones, and some grant if any hit
  a_r7_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r7_grant_in_hits: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & ~hit_vec) == '0) && ((|hit_vec) == (|grant)));
  // R8: hit and miss exclusive
  a_r8_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_miss));
  // R9: bypassed traffic passes through with no flags
  a_r9_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_bypass) |=> (rsp_addr == $past(req_addr)) && !rsp_hit && !rsp_miss);
  // R10: an accepted request is valid on the next cycle
  a_r10_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
  // R11: a stalled result holds
  a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_win)
                                  && $stable(rsp_hit) && $stable(rsp_io));
endmodule

// File: tb/obw_translator_tb.sv
module obw_translator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        glb_en = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        req_bypass = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_addr;
  logic        rsp_io, rsp_hit, rsp_miss;
  logic [2:0]  rsp_win;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  obw_translator dut_i (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_bypass(req_bypass),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
    .rsp_io(rsp_io), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_win(rsp_win)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int w, input int ofs, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'((w << 5) | ofs); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input int w, input int ofs, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 8'((w << 5) | ofs);
    #2 d = cfg_rdata;
  endtask

  task automatic set_win(input int w, input logic [63:0] cmp, input logic [63:0] msk,
                         input logic [63:0] rep, input logic [31:0] act);
    wr(w, 5'h00, cmp[31:0] & ~32'h1);
    wr(w, 5'h04, cmp[63:32]);
    wr(w, 5'h08, rep[31:0]);
    wr(w, 5'h0C, rep[63:32]);
    wr(w, 5'h10, msk[31:0]);
    wr(w, 5'h14, msk[63:32]);
    wr(w, 5'h18, act);
    wr(w, 5'h00, cmp[31:0] | 32'h1);
  endtask

  task automatic xlate(input string tag, input logic [63:0] a, input logic byp,
                       input logic [63:0] ea, input logic eio, input logic ehit,
                       input logic emiss, input logic [2:0] ewin);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_bypass = byp; rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk({tag, " addr"},  rsp_addr, ea);
    chk({tag, " io"},    64'(rsp_io), 64'(eio));
    chk({tag, " hit"},   64'(rsp_hit), 64'(ehit));
    chk({tag, " miss"},  64'(rsp_miss), 64'(emiss));
    chk({tag, " win"},   64'(rsp_win), 64'(ewin));
    @(negedge clk);
    req_valid = 1'b0; req_bypass = 1'b0;
  endtask

  localparam logic [63:0] MSK256 = 64'hFFFF_FFFF_F000_0000;
  localparam logic [63:0] MSK2G  = 64'hFFFF_FFFF_8000_0000;

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    rd(0, 5'h00, d); chk("R1 w0 cmp_lo", 64'(d), 64'd0);
    rd(7, 5'h18, d); chk("R1 w7 act", 64'(d), 64'd0);
    xlate("R1 all off miss", 64'h8000_0000, 1'b0, 64'h8000_0000, 0, 0, 1, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(7, 5'h18, 32'hA5A5_0004);
    rd(7, 5'h18, d); chk("R2 w7 act readback", 64'(d), 64'hA5A5_0004);
    wr(3, 5'h14, 32'h1234_5678);
    rd(3, 5'h14, d); chk("R2 w3 msk_hi readback", 64'(d), 64'h1234_5678);
    wr(3, 5'h1C, 32'hFFFF_FFFF);
    rd(3, 5'h1C, d); chk("R2 spare slot reads 0", 64'(d), 64'd0);
    rd(3, 5'h18, d); chk("R2 spare write ignored", 64'(d), 64'd0);
    wr(3, 5'h14, 32'h0);
    wr(7, 5'h18, 32'h0);
  endtask

  task automatic t_main();
    set_win(0, 64'h8000_0000, MSK256, 64'h10_0000_0000, 32'h0);
    set_win(1, 64'h9000_0000, MSK256, 64'h0, 32'h4);
    set_win(2, 64'h8000_0000, MSK2G,  64'h20_0000_0000, 32'h0);
    set_win(5, 64'h1_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2_0000_0000, 32'h4);
    xlate("R7 R5 overlap lowest wins", 64'h8123_4567, 0, 64'h10_0123_4567, 0, 1, 0, 0);
    xlate("R5 w2 translation", 64'hA000_0010, 0, 64'h20_2000_0010, 0, 1, 0, 2);
    xlate("R6 io kind", 64'h9000_0ABC, 0, 64'h0ABC, 1, 1, 0, 1);
    xlate("R8 miss passthru", 64'h1234_5678, 0, 64'h1234_5678, 0, 0, 1, 0);
    xlate("R4 high bits compared", 64'h1_8000_0000, 0, 64'h1_8000_0000, 0, 0, 1, 0);
    xlate("R4 bit0 excluded a", 64'h1_0000_0000, 0, 64'h2_0000_0000, 1, 1, 0, 5);
    xlate("R4 bit0 excluded b", 64'h1_0000_0001, 0, 64'h2_0000_0000, 1, 1, 0, 5);
  endtask

  task automatic t_disarm();
    wr(0, 5'h00, 32'h8000_0000);
    xlate("R3 disarmed w0 skipped", 64'h8123_4567, 0, 64'h20_0123_4567, 0, 1, 0, 2);
    wr(0, 5'h00, 32'h8000_0001);
    xlate("R3 rearmed w0", 64'h8123_4567, 0, 64'h10_0123_4567, 0, 1, 0, 0);
  endtask

  task automatic t_bypass();
    @(negedge clk); glb_en = 1'b0;
    xlate("R9 global off", 64'h9000_0ABC, 0, 64'h9000_0ABC, 0, 0, 0, 0);
    @(negedge clk); glb_en = 1'b1;
    xlate("R9 bypass flag", 64'h8123_4567, 1, 64'h8123_4567, 0, 0, 0, 0);
  endtask

  task automatic t_same_cycle();
    wr(6, 5'h04, 32'h40);
    wr(6, 5'h08, 32'h0);
    wr(6, 5'h0C, 32'h3);
    wr(6, 5'h10, 32'h0);
    wr(6, 5'h14, 32'hFFFF_FFFF);
    wr(6, 5'h18, 32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 8'((6 << 5) | 0); cfg_wdata = 32'h1;
    req_valid = 1'b1; req_addr = 64'h40_0000_1000; rsp_ready = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    chk("R10 same-edge arm uses old state miss", 64'(rsp_miss), 64'd1);
    chk("R10 same-edge arm addr", rsp_addr, 64'h40_0000_1000);
    @(negedge clk); req_valid = 1'b0;
    xlate("R10 armed next lookup", 64'h40_0000_1000, 0, 64'h3_0000_1000, 0, 1, 0, 6);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 64'h9000_0ABC;
    @(posedge clk); #1;
    chk("R11 first result", rsp_addr, 64'h0ABC);
    chk("R11 ready low in stall", 64'(req_ready), 64'd0);
    @(negedge clk); req_addr = 64'h9000_0DEF;
    repeat (2) @(posedge clk);
    #1;
    chk("R11 held addr", rsp_addr, 64'h0ABC);
    chk("R11 held valid", 64'(rsp_valid), 64'd1);
    chk("R11 still not ready", 64'(req_ready), 64'd0);
    @(negedge clk); rsp_ready = 1'b1;
    #1 chk("R11 ready follows rsp_ready", 64'(req_ready), 64'd1);
    @(posedge clk); #1;
    chk("R11 waiting request taken", rsp_addr, 64'h0DEF);
    chk("R11 waiting request io", 64'(rsp_io), 64'd1);
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R11 drained", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_main();
    t_disarm();
    t_bypass();
    t_same_cycle();
    t_backpressure();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule